// File: doc/BRIEF.md
# Millisecond Tick Generator with Frequency-Coded Configuration

This block produces a single-cycle pulse once every millisecond of its input clock. Software does not program a divider directly. It states the clock frequency as a 10-bit number plus a unit bit, and the block derives the divide ratio from those two values. With the unit bit set, the number counts megahertz. With it clear, the number counts kilohertz. The resulting tick drives every millisecond timer in the surrounding logic.

The configuration lives in one small register that can be read back. Writing it restarts the internal count, so the first tick under the new setting comes one full period after the write. Speeds below the legal minimum are raised to that minimum, so the block can never pulse on every cycle.

Two named states form the core. `ST_COUNT` counts clock cycles. `ST_PULSE` is the single cycle in which the tick is high. Three transitions connect them:
- `T_WRAP`: `ST_COUNT` moves to `ST_PULSE` when the count reaches the period minus one.
- `T_RESUME`: `ST_PULSE` returns to `ST_COUNT` after one cycle.
- `T_RESTART`: any state returns to `ST_COUNT` with the count cleared when the register is written.

Top module: `mstick_gen`

## Requirements
- R1: While reset is asserted, `tick` is low and `cfg_rdata` reads 0x0C1, which means MHz units (bit 0 = 1) and speed 48 (bits 11:2).
- R2: After reset with no write, the first tick appears exactly 48000 clock cycles after the first active edge count starts, counting the releasing edge as cycle 1.
- R3: With unit bit 0 (kHz), the tick period is `speed` cycles. This holds across the range 4 to 1023.
- R4: With unit bit 1 (MHz), the tick period is `speed` × 1000 cycles.
- R5: A write to the configuration clears the count. The next tick follows exactly one new period after the write edge, even when the write arrives partway through a period, and no tick appears between the write and that first tick.
- R6: In kHz units, a speed below 4 is treated as 4.
- R7: In MHz units, a speed of 0 is treated as 1, which gives a 1000-cycle period.
- R8: Every tick is high for exactly one cycle, and two ticks are always at least 4 cycles apart.
- R9: `cfg_rdata` returns the last written unit bit at bit 0 and the speed at bits 11:2. Bit 1 always reads 0, whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 12 | Write data: bit 0 = unit (1 = MHz), bits 11:2 = speed |
| cfg_rdata | output | 12 | Configuration readback, same layout as write data, bit 1 reads 0 |
| tick | output | 1 | One-cycle pulse once per millisecond |

## Verification
Several properties are checked by assertions on every clock cycle:
- the register value straight after reset;
- the write-to-readback path, including the masked bit 1;
- that `tick` is one cycle wide;
- that `tick` stays quiet on the cycle after a write;
- that ticks are never closer than four cycles.

The exact period under each unit, the clamping of small speeds, and the exact placement of the first tick after a write or after reset cannot be seen one cycle at a time. A bench scoreboard shows these. It predicts the cycle number of every tick and rejects any tick it did not predict.

// File: rtl/mstick_pkg.sv
package mstick_pkg;

    // Tick generator states.
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_PULSE = 1'b1
    } tick_state_e;

    // Encoding of the unit bit.
    localparam logic UNIT_KHZ = 1'b0;
    localparam logic UNIT_MHZ = 1'b1;

endpackage

// File: rtl/mstick_cfg_reg.sv
module mstick_cfg_reg #(
    parameter int          SPEED_W   = 10,
    parameter int          RST_SPEED = 48,
    parameter logic        RST_UNIT  = 1'b1,
    localparam int         CFG_W     = SPEED_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic               unit_o,
    output logic [SPEED_W-1:0] speed_o,
    output logic [CFG_W-1:0]   rdata
);

    logic unused_bit;
    assign unused_bit = wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_o  <= RST_UNIT;
            speed_o <= SPEED_W'(RST_SPEED);
        end else if (we) begin
            unit_o  <= wdata[0];
            speed_o <= wdata[CFG_W-1:2];
        end
    end

    // Bit 1 is a gap in the layout and always reads zero.
    assign rdata = {speed_o, 1'b0, unit_o};

endmodule

// File: rtl/mstick_ratio.sv
module mstick_ratio #(
    parameter int  SPEED_W  = 10,
    parameter int  MHZ_MULT = 1000,
    parameter int  KHZ_MIN  = 4,
    parameter int  MHZ_MIN  = 1,
    parameter int  PER_W    = 20
) (
    input  logic               unit_i,
    input  logic [SPEED_W-1:0] speed_i,
    output logic [PER_W-1:0]   period_o
);
    import mstick_pkg::*;

    logic [PER_W-1:0] spd_ext;
    logic [PER_W-1:0] khz_per;
    logic [PER_W-1:0] mhz_base;
    logic [PER_W-1:0] mhz_per;

    assign spd_ext = PER_W'(speed_i);

    // Raise any speed below the legal floor for its unit.
    always_comb begin
        khz_per  = (spd_ext < PER_W'(KHZ_MIN)) ? PER_W'(KHZ_MIN) : spd_ext;
        mhz_base = (spd_ext < PER_W'(MHZ_MIN)) ? PER_W'(MHZ_MIN) : spd_ext;
    end

    // A multiplier of one needs no multiply at all.
    generate
        if (MHZ_MULT == 1) begin : g_no_mult
            assign mhz_per = mhz_base;
        end else begin : g_mult
            assign mhz_per = mhz_base * PER_W'(MHZ_MULT);
        end
    endgenerate

    assign period_o = (unit_i == UNIT_MHZ) ? mhz_per : khz_per;

endmodule

// File: rtl/mstick_fsm.sv
module mstick_fsm #(
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    import mstick_pkg::*;

    tick_state_e      state_q, state_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic             at_end;

    assign at_end = (cnt_q == period - PER_W'(1));

    // Next state and count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + PER_W'(1);
        if (restart) begin
            // T_RESTART
            state_d = ST_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (at_end) begin
                        // T_WRAP
                        state_d = ST_PULSE;
                        cnt_d   = '0;
                    end
                end
                ST_PULSE: begin
                    // T_RESUME
                    state_d = ST_COUNT;
                end
                default: begin
                    state_d = ST_COUNT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_PULSE: tick = 1'b1;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/mstick_gen.sv
module mstick_gen #(
    parameter int   SPEED_W   = 10,
    parameter int   MHZ_MULT  = 1000,
    parameter int   KHZ_MIN   = 4,
    parameter int   MHZ_MIN   = 1,
    parameter int   RST_SPEED = 48,
    parameter logic RST_UNIT  = 1'b1,
    localparam int  CFG_W     = SPEED_W + 2,
    localparam int  MAX_PER   = ((1 << SPEED_W) - 1) * MHZ_MULT,
    localparam int  PER_W     = $clog2(MAX_PER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             tick
);

    logic               unit_w;
    logic [SPEED_W-1:0] speed_w;
    logic [PER_W-1:0]   period_w;

    mstick_cfg_reg #(
        .SPEED_W   (SPEED_W),
        .RST_SPEED (RST_SPEED),
        .RST_UNIT  (RST_UNIT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .unit_o  (unit_w),
        .speed_o (speed_w),
        .rdata   (cfg_rdata)
    );

    mstick_ratio #(
        .SPEED_W  (SPEED_W),
        .MHZ_MULT (MHZ_MULT),
        .KHZ_MIN  (KHZ_MIN),
        .MHZ_MIN  (MHZ_MIN),
        .PER_W    (PER_W)
    ) u_ratio (
        .unit_i   (unit_w),
        .speed_i  (speed_w),
        .period_o (period_w)
    );

    mstick_fsm #(
        .PER_W (PER_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .period  (period_w),
        .tick    (tick)
    );

endmodule

// File: rtl/mstick_gen_chk.sv
module mstick_gen_chk #(
    parameter int  SPEED_W   = 10,
    parameter int  RST_SPEED = 48,
    parameter logic RST_UNIT = 1'b1,
    localparam int CFG_W     = SPEED_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             tick
);

    localparam logic [CFG_W-1:0] RST_CFG = {SPEED_W'(RST_SPEED), 1'b0, RST_UNIT};

    // R1: the first sampled edge after reset sees the reset configuration.
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cfg_rdata == RST_CFG);

    // R9: readback mirrors the written unit and speed, with bit 1 forced to zero.
    a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == {$past(cfg_wdata[CFG_W-1:2]), 1'b0, $past(cfg_wdata[0])});

    // R8: the pulse lasts one cycle only.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: no two pulses are closer than four cycles.
    a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !$past(tick, 1) && !$past(tick, 2) && !$past(tick, 3));

    // R5: a write restarts the count, so the next cycle carries no pulse.
    a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tick);

endmodule

bind mstick_gen mstick_gen_chk #(
    .SPEED_W   (SPEED_W),
    .RST_SPEED (RST_SPEED),
    .RST_UNIT  (RST_UNIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick      (tick)
);

// File: tb/test_mstick_gen.sv
`timescale 1ns/1ps
module test_mstick_gen;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        tick;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    bit   prev_tick = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    mstick_gen i_mstick_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick      (tick)
    );

    always @(posedge clk) cyc++;

    // Scoreboard monitor: every tick must match the next predicted cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tick) begin
                checks++;
                if (prev_tick) begin
                    fails++;
                    $display("FAIL R8 tick wide at cycle %0d: actual 1 expected 0", cyc);
                end
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R5 unexpected tick at cycle %0d: actual tick expected none", cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.at != cyc) begin
                        fails++;
                        $display("FAIL %s tick cycle: actual %0d expected %0d", e.req, cyc, e.at);
                    end
                end
            end
            prev_tick = tick;
        end
    end

    function automatic int period_of(input bit unit, input int speed);
        if (unit) return ((speed < 1) ? 1 : speed) * 1000;
        return (speed < 4) ? 4 : speed;
    endfunction

    task automatic cfg_write(input bit unit, input int speed, input bit gap_bit,
                             input int n, input string req);
        int w;
        int p;
        @(negedge clk);
        w = cyc + 1;
        p = period_of(unit, speed);
        cfg_wdata = {speed[9:0], gap_bit, unit};
        cfg_we = 1'b1;
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.at  = w + k * p;
            e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic chk_rd(input logic [11:0] exp, input string req);
        @(negedge clk);
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s readback: actual 0x%03h expected 0x%03h", req, cfg_rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (tick !== 1'b0) begin
            fails++;
            $display("FAIL R1 tick in reset: actual %b expected 0", tick);
        end
        chk_rd(12'h0C1, "R1");
        // R2: default 48 MHz, first tick 48000 cycles after release
        begin
            exp_t e;
            e.at  = cyc + 48000;
            e.req = "R2";
            sb.push_back(e);
        end
        rst_n = 1'b1;
        drain();

        // R3: kHz units
        cfg_write(1'b0, 10, 1'b0, 3, "R3");
        chk_rd(12'h028, "R9");
        drain();
        cfg_write(1'b0, 1023, 1'b0, 1, "R3");
        drain();
        // R4: MHz units
        cfg_write(1'b1, 1, 1'b0, 2, "R4");
        drain();
        cfg_write(1'b1, 2, 1'b0, 2, "R4");
        drain();
        // R7: MHz speed zero clamps to one
        cfg_write(1'b1, 0, 1'b0, 2, "R7");
        drain();
        // R6: kHz clamp
        cfg_write(1'b0, 0, 1'b0, 2, "R6");
        drain();
        cfg_write(1'b0, 3, 1'b1, 2, "R6");
        chk_rd(12'h00C, "R9");
        drain();
        // R5: write in the middle of a period
        cfg_write(1'b0, 20, 1'b0, 1, "R5");
        drain();
        repeat (7) @(negedge clk);
        cfg_write(1'b0, 9, 1'b0, 3, "R5");
        drain();
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 190000);
        done = 1;
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule